// File: doc/BRIEF.md
# USB Control Endpoint Handshake Sequencer

This block sequences endpoint zero of a USB device through control transfers at the token and packet level. Its input is a stream that has already been decoded: token strobes carrying a PID (SETUP, IN or OUT) and an endpoint number, data bytes, and an end-of-packet strobe with a CRC-good flag. It captures the SETUP data packet into a register buffer and raises two sticky interrupt flags, one when a SETUP token arrives and one when its data has been captured. It answers the handshake of the SETUP data packet. It also answers status-stage and stalled data-stage tokens with ACK, NAK or STALL.

Firmware steers the transfer through a three-bit write port. A hold bit is armed by every SETUP token. While it is set, the status stage is answered with NAK. Writing one to the hold bit releases it, and the next status token is then acknowledged, which ends the transfer. A stall bit takes effect only once the hold has been released. An arm bit declares that a data stage exists. Its direction, taken from bit 7 of the first SETUP byte, decides which token direction counts as the status stage. Data-stage tokens that are not stalled are passed to a separate data engine through a one-cycle strobe.

Top module: `ep0_hs_seq`

## Requirements
- R1: After reset `hs_valid`, `data_tok`, `irq_setup_tok`, `irq_setup_data`, `hold` and `stall` are 0, and `setup_data` is all zeros.
- R2: A SETUP token (`tok_pid`=2) for endpoint 0 sets `irq_setup_tok` and `hold` and clears `stall` in the next cycle. Tokens for any other endpoint produce no flag, no handshake and no `data_tok`.
- R3: A SETUP data packet of exactly 8 bytes with a good CRC yields `hs_valid` with `hs_code`=ACK (0) one cycle after `pkt_end`. In that same cycle `irq_setup_data` is set and `setup_data` holds the bytes, with byte k at bits [8k+7:8k].
- R4: A SETUP data packet with a bad CRC, or with a length other than 8, gives no handshake, leaves `irq_setup_data` clear and leaves `setup_data` unchanged.
- R5: The SETUP stage is never stalled. A stall bit set before the SETUP token is cleared by that token, and the SETUP data packet is still ACKed.
- R6: The status direction is OUT (`tok_pid`=0) when the arm bit (`fw_wdata[2]` of a control write) is set and bit 7 of SETUP byte 0 is 1. Otherwise it is IN (`tok_pid`=1).
- R7: While `hold` is 1, each status-stage token is answered with NAK (`hs_code`=1), as often as the token repeats.
- R8: A control write (`fw_sel`=0) with `fw_wdata[0]`=1 clears `hold`. The next status token is then ACKed and the transfer ends, so later IN/OUT tokens give no response and no `data_tok`.
- R9: When `stall` (`fw_wdata[1]` of a control write) is 1 and `hold` is 0, data-stage and status-stage tokens are answered with STALL (`hs_code`=2). With `hold` still 1, the status stage gets NAK.
- R10: A token in the data-stage direction with no active stall produces a one-cycle `data_tok` and no handshake.
- R11: For OUT tokens, the handshake comes one cycle after the `pkt_end` of the following data packet and never at the token itself.
- R12: Both interrupt flags are sticky. An interrupt write (`fw_sel`=1) with bit 0 clears `irq_setup_tok` and with bit 1 clears `irq_setup_data`. A set in the same cycle wins over the clear.
- R13: A SETUP token in the middle of a transfer aborts it: a pending OUT response is dropped, and the arm bit is cleared along with the stall bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_ep | input | 4 | Token endpoint number |
| dat_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte |
| pkt_end | input | 1 | End of a data packet |
| pkt_crc_ok | input | 1 | CRC good, valid with `pkt_end` |
| fw_we | input | 1 | Firmware write strobe |
| fw_sel | input | 1 | 0 control bits, 1 interrupt flags |
| fw_wdata | input | 3 | Write data |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 0 ACK (or zero-length reply on IN), 1 NAK, 2 STALL |
| data_tok | output | 1 | Data-stage token handed to the data engine |
| irq_setup_tok | output | 1 | SETUP token flag |
| irq_setup_data | output | 1 | SETUP data captured flag |
| hold | output | 1 | Status-stage hold bit |
| stall | output | 1 | Endpoint zero stall bit |
| setup_data | output | 64 | Captured SETUP bytes, byte 0 in the low bits |

## Verification
The bench uses the defaults: 8 SETUP bytes of 8 bits and a 4-bit endpoint field. With these values, packets of 7 and 9 bytes test both sides of the length check, and a 9-byte packet drives the byte counter into saturation. Endpoint 3 serves as the foreign endpoint. Because the buffer is 64 bits wide, a single word comparison checks the byte order of every random SETUP packet. The random arm bit and byte-0 direction bit cover both status directions across repeated NAK counts.

// File: rtl/ep0_hs_pkg.sv
// Shared encodings for the endpoint-zero handshake sequencer.
package ep0_hs_pkg;
    typedef enum logic [1:0] {
        PID_OUT   = 2'd0,
        PID_IN    = 2'd1,
        PID_SETUP = 2'd2,
        PID_RSVD  = 2'd3
    } tok_pid_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_NONE  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP_PKT,
        PH_XFER
    } phase_e;

    localparam int CTRL_HOLD_BIT  = 0;
    localparam int CTRL_STALL_BIT = 1;
    localparam int CTRL_ARM_BIT   = 2;
    localparam int IRQ_TOK_BIT    = 0;
    localparam int IRQ_DATA_BIT   = 1;
endpackage

// File: rtl/ep0_setup_buf.sv
// Captures the SETUP data packet into a staging array and counts its bytes.
// On commit the staged bytes are copied into the firmware-visible buffer.
// Assumes bytes arrive only between a SETUP token and the next pkt_end.
module ep0_setup_buf #(
    parameter int LEN = 8,
    parameter int BW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture_en,
    input  logic              byte_valid,
    input  logic [BW-1:0]     byte_in,
    input  logic              commit,
    output logic              len_ok,
    output logic [LEN*BW-1:0] setup_data
);
    localparam int CW = $clog2(LEN + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(LEN);
    localparam logic [CW-1:0] CNT_OVER = CW'(LEN + 1);

    logic [CW-1:0] cnt_q;
    logic [BW-1:0] stage_q [LEN];

    // Byte counter, saturating one past the expected length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (capture_en && byte_valid && cnt_q != CNT_OVER) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign len_ok = (cnt_q == CNT_FULL);

    for (genvar k = 0; k < LEN; k++) begin : g_byte
        // Stage byte k as it arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[k] <= '0;
            end else if (capture_en && byte_valid && cnt_q == CW'(k)) begin
                stage_q[k] <= byte_in;
            end
        end

        // Publish byte k when the packet has been accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                setup_data[k*BW +: BW] <= '0;
            end else if (commit) begin
                setup_data[k*BW +: BW] <= stage_q[k];
            end
        end
    end

    assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(setup_data));
endmodule

// File: rtl/ep0_fw_regs.sv
// Firmware control bits (hold, stall, arm) and the two sticky interrupt flags.
// Hardware events take priority over a firmware write in the same cycle.
module ep0_fw_regs #(
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_we,
    input  logic          fw_sel,
    input  logic [WW-1:0] fw_wdata,
    input  logic          setup_start,
    input  logic          tok_set,
    input  logic          data_set,
    output logic          hold,
    output logic          stall,
    output logic          arm,
    output logic          irq_tok,
    output logic          irq_data
);
    import ep0_hs_pkg::*;

    logic ctrl_wr, irq_wr;
    assign ctrl_wr = fw_we && !fw_sel;
    assign irq_wr  = fw_we && fw_sel;

    // Control bits: a SETUP token re-arms hold and drops stall and arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= 1'b0;
            stall <= 1'b0;
            arm   <= 1'b0;
        end else if (setup_start) begin
            hold  <= 1'b1;
            stall <= 1'b0;
            arm   <= 1'b0;
        end else if (ctrl_wr) begin
            if (fw_wdata[CTRL_HOLD_BIT]) hold <= 1'b0;
            stall <= fw_wdata[CTRL_STALL_BIT];
            arm   <= fw_wdata[CTRL_ARM_BIT];
        end
    end

    // Sticky flags, cleared by a write of one, with set winning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tok  <= 1'b0;
            irq_data <= 1'b0;
        end else begin
            if (tok_set)                                irq_tok <= 1'b1;
            else if (irq_wr && fw_wdata[IRQ_TOK_BIT])   irq_tok <= 1'b0;
            if (data_set)                               irq_data <= 1'b1;
            else if (irq_wr && fw_wdata[IRQ_DATA_BIT])  irq_data <= 1'b0;
        end
    end

    assert_setup_rearm_R13: assert property (@(posedge clk) disable iff (!rst_n)
        setup_start |=> hold && !stall && !arm);
    assert_tok_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tok_set |=> irq_tok);
    assert_data_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        data_set |=> irq_data);
endmodule

// File: rtl/ep0_hs_fsm.sv
// Phase sequencer: follows SETUP, data and status stages of endpoint zero,
// decides the handshake for each token and hands data-stage tokens onward.
// Assumes a token and a pkt_end never share a cycle.
module ep0_hs_fsm #(
    parameter int EPW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tok_valid,
    input  ep0_hs_pkg::tok_pid_e  tok_pid,
    input  logic [EPW-1:0]        tok_ep,
    input  logic                  pkt_end,
    input  logic                  pkt_crc_ok,
    input  logic                  len_ok,
    input  logic                  hold,
    input  logic                  stall,
    input  logic                  arm,
    input  logic                  dir_in_bit,
    output logic                  setup_start,
    output logic                  capture_en,
    output logic                  commit,
    output logic                  hs_valid,
    output ep0_hs_pkg::rsp_e      hs_code,
    output logic                  data_tok
);
    import ep0_hs_pkg::*;

    phase_e   phase_q;
    logic     pend_out_q, pend_status_q;
    logic     ep0_tok, stall_now;
    tok_pid_e status_pid;
    rsp_e     status_rsp;

    assign ep0_tok     = tok_valid && (tok_ep == '0);
    assign setup_start = ep0_tok && (tok_pid == PID_SETUP);
    assign capture_en  = (phase_q == PH_SETUP_PKT);
    assign commit      = capture_en && pkt_end && pkt_crc_ok && len_ok && !setup_start;
    assign stall_now   = stall && !hold;
    assign status_pid  = (arm && dir_in_bit) ? PID_OUT : PID_IN;

    // Status-stage answer from the firmware bits.
    always_comb begin
        if (stall_now)  status_rsp = RSP_STALL;
        else if (hold)  status_rsp = RSP_NAK;
        else            status_rsp = RSP_ACK;
    end

    // Phase tracking, pending OUT bookkeeping and registered responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q       <= PH_IDLE;
            pend_out_q    <= 1'b0;
            pend_status_q <= 1'b0;
            hs_valid      <= 1'b0;
            hs_code       <= RSP_ACK;
            data_tok      <= 1'b0;
        end else begin
            hs_valid <= 1'b0;
            data_tok <= 1'b0;
            if (setup_start) begin
                phase_q       <= PH_SETUP_PKT;
                pend_out_q    <= 1'b0;
                pend_status_q <= 1'b0;
            end else begin
                case (phase_q)
                    PH_SETUP_PKT: begin
                        if (pkt_end) begin
                            if (commit) begin
                                phase_q  <= PH_XFER;
                                hs_valid <= 1'b1;
                                hs_code  <= RSP_ACK;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                    end
                    PH_XFER: begin
                        if (ep0_tok && tok_pid == PID_IN) begin
                            if (status_pid == PID_IN) begin
                                hs_valid <= 1'b1;
                                hs_code  <= status_rsp;
                                if (status_rsp == RSP_ACK) begin
                                    phase_q    <= PH_IDLE;
                                    pend_out_q <= 1'b0;
                                end
                            end else if (stall_now) begin
                                hs_valid <= 1'b1;
                                hs_code  <= RSP_STALL;
                            end else begin
                                data_tok <= 1'b1;
                            end
                        end else if (ep0_tok && tok_pid == PID_OUT) begin
                            pend_out_q    <= 1'b1;
                            pend_status_q <= (status_pid == PID_OUT);
                            if (status_pid != PID_OUT && !stall_now) data_tok <= 1'b1;
                        end else if (pkt_end && pend_out_q) begin
                            pend_out_q <= 1'b0;
                            if (pend_status_q) begin
                                hs_valid <= 1'b1;
                                hs_code  <= status_rsp;
                                if (status_rsp == RSP_ACK) phase_q <= PH_IDLE;
                            end else if (stall_now) begin
                                hs_valid <= 1'b1;
                                hs_code  <= RSP_STALL;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_stall_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid && hs_code == RSP_STALL |-> $past(stall && !hold));
    assert_nak_on_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid && hs_code == RSP_NAK |-> $past(hold));
    assert_setup_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> hs_valid && hs_code == RSP_ACK);
    assert_single_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_valid && data_tok));
    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> hs_code != RSP_NONE);
endmodule

// File: rtl/ep0_hs_seq.sv
// Top of the endpoint-zero handshake sequencer: joins the phase sequencer,
// the SETUP buffer and the firmware register bits.
// Assumes a decoded token/packet stream, one event per cycle.
module ep0_hs_seq #(
    parameter int SETUP_LEN = 8,
    parameter int BYTE_W    = 8,
    parameter int EP_W      = 4,
    parameter int FW_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tok_valid,
    input  logic [1:0]                  tok_pid,
    input  logic [EP_W-1:0]             tok_ep,
    input  logic                        dat_valid,
    input  logic [BYTE_W-1:0]           dat_byte,
    input  logic                        pkt_end,
    input  logic                        pkt_crc_ok,
    input  logic                        fw_we,
    input  logic                        fw_sel,
    input  logic [FW_W-1:0]             fw_wdata,
    output logic                        hs_valid,
    output logic [1:0]                  hs_code,
    output logic                        data_tok,
    output logic                        irq_setup_tok,
    output logic                        irq_setup_data,
    output logic                        hold,
    output logic                        stall,
    output logic [SETUP_LEN*BYTE_W-1:0] setup_data
);
    import ep0_hs_pkg::*;

    tok_pid_e pid_t;
    rsp_e     rsp_t;
    logic     setup_start, capture_en, commit, len_ok, arm;

    assign pid_t   = tok_pid_e'(tok_pid);
    assign hs_code = rsp_t;

    ep0_hs_fsm #(.EPW(EP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_pid(pid_t), .tok_ep(tok_ep),
        .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .len_ok(len_ok),
        .hold(hold), .stall(stall), .arm(arm),
        .dir_in_bit(setup_data[BYTE_W-1]),
        .setup_start(setup_start), .capture_en(capture_en), .commit(commit),
        .hs_valid(hs_valid), .hs_code(rsp_t), .data_tok(data_tok)
    );

    ep0_setup_buf #(.LEN(SETUP_LEN), .BW(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear(setup_start), .capture_en(capture_en),
        .byte_valid(dat_valid), .byte_in(dat_byte),
        .commit(commit), .len_ok(len_ok), .setup_data(setup_data)
    );

    ep0_fw_regs #(.WW(FW_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .fw_we(fw_we), .fw_sel(fw_sel), .fw_wdata(fw_wdata),
        .setup_start(setup_start), .tok_set(setup_start), .data_set(commit),
        .hold(hold), .stall(stall), .arm(arm),
        .irq_tok(irq_setup_tok), .irq_data(irq_setup_data)
    );

    assert_foreign_ep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_ep != '0 && !pkt_end |=> !hs_valid && !data_tok);
endmodule

// File: tb/ep0_hs_seq_test.sv
module ep0_hs_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_pid = 2'd0;
    logic [3:0]  tok_ep = 4'd0;
    logic        dat_valid = 1'b0;
    logic [7:0]  dat_byte = 8'd0;
    logic        pkt_end = 1'b0;
    logic        pkt_crc_ok = 1'b0;
    logic        fw_we = 1'b0;
    logic        fw_sel = 1'b0;
    logic [2:0]  fw_wdata = 3'd0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        data_tok;
    logic        irq_setup_tok, irq_setup_data, hold, stall;
    logic [63:0] setup_data;

    localparam logic [1:0] P_OUT = 2'd0, P_IN = 2'd1, P_SETUP = 2'd2;
    localparam logic [1:0] C_ACK = 2'd0, C_NAK = 2'd1, C_STALL = 2'd2;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] pbytes [0:15];

    ep0_hs_seq uut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
        .tok_ep(tok_ep), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .fw_we(fw_we),
        .fw_sel(fw_sel), .fw_wdata(fw_wdata), .hs_valid(hs_valid),
        .hs_code(hs_code), .data_tok(data_tok), .irq_setup_tok(irq_setup_tok),
        .irq_setup_data(irq_setup_data), .hold(hold), .stall(stall),
        .setup_data(setup_data)
    );

    always #4 clk = ~clk;

    function automatic logic [1:0] exp_status_pid(input bit armed, input logic [7:0] b0);
        return (armed && b0[7]) ? P_OUT : P_IN;
    endfunction

    function automatic logic [63:0] packed_bytes();
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = pbytes[k];
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_tok(input logic [1:0] pid, input logic [3:0] ep);
        tok_valid = 1'b1; tok_pid = pid; tok_ep = ep;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic send_pkt(input int n, input bit crc);
        for (int i = 0; i < n; i++) begin
            dat_valid = 1'b1; dat_byte = pbytes[i];
            @(negedge clk);
        end
        dat_valid = 1'b0; pkt_end = 1'b1; pkt_crc_ok = crc;
        @(negedge clk);
        pkt_end = 1'b0; pkt_crc_ok = 1'b0;
    endtask

    task automatic fw_write(input bit sel, input logic [2:0] d);
        fw_we = 1'b1; fw_sel = sel; fw_wdata = d;
        @(negedge clk);
        fw_we = 1'b0;
    endtask

    task automatic rand_bytes();
        for (int i = 0; i < 16; i++) pbytes[i] = 8'($urandom);
    endtask

    // Open a transfer with a good SETUP packet and check its acceptance.
    task automatic open_xfer(input string tag);
        send_tok(P_SETUP, 4'd0);
        send_pkt(8, 1'b1);
        chk({tag, " setup ack"}, {hs_valid, hs_code}, {1'b1, C_ACK});
        chk({tag, " setup data"}, setup_data, packed_bytes());
    endtask

    // Run one status-stage token and leave the handshake on the outputs.
    task automatic status_tok(input logic [1:0] pid);
        send_tok(pid, 4'd0);
        if (pid == P_OUT) begin
            chk("R11 no handshake at OUT token", hs_valid, 1'b0);
            send_pkt(0, 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] keep;
        void'($urandom(32'h1d5e_ed01));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset outputs", {hs_valid, data_tok, irq_setup_tok, irq_setup_data, hold, stall}, 6'd0);
        chk("R1 reset setup_data", setup_data, 64'd0);

        // R2 foreign endpoint ignored, endpoint zero flagged
        send_tok(P_SETUP, 4'd3);
        chk("R2 foreign ep ignored", {irq_setup_tok, hold, hs_valid, data_tok}, 4'd0);
        send_tok(P_SETUP, 4'd0);
        chk("R2 setup token flag/hold", {irq_setup_tok, hold, stall}, 3'b110);

        // R3 good packet captured
        rand_bytes();
        send_pkt(8, 1'b1);
        chk("R3 ack after setup data", {hs_valid, hs_code}, {1'b1, C_ACK});
        chk("R3 data flag", irq_setup_data, 1'b1);
        chk("R3 buffer order", setup_data, packed_bytes());

        // R12 write-one clear of both flags
        fw_write(1'b1, 3'b011);
        chk("R12 flags cleared", {irq_setup_tok, irq_setup_data}, 2'b00);

        // R4 bad CRC, short and long packets rejected
        keep = setup_data;
        rand_bytes();
        send_tok(P_SETUP, 4'd0);
        send_pkt(8, 1'b0);
        chk("R4 bad crc no handshake", {hs_valid, irq_setup_data}, 2'b00);
        chk("R4 bad crc buffer kept", setup_data, keep);
        send_tok(P_SETUP, 4'd0);
        send_pkt(7, 1'b1);
        chk("R4 short packet rejected", {hs_valid, irq_setup_data}, 2'b00);
        send_tok(P_SETUP, 4'd0);
        send_pkt(9, 1'b1);
        chk("R4 long packet rejected", {hs_valid, irq_setup_data}, 2'b00);
        chk("R4 buffer kept after length error", setup_data, keep);
        fw_write(1'b1, 3'b011);

        // R5 stall before SETUP is dropped, SETUP still ACKed
        fw_write(1'b0, 3'b010);
        chk("R5 stall set", stall, 1'b1);
        send_tok(P_SETUP, 4'd0);
        chk("R5 setup clears stall", stall, 1'b0);
        rand_bytes();
        pbytes[0][7] = 1'b0;
        send_pkt(8, 1'b1);
        chk("R5 setup never stalled", {hs_valid, hs_code}, {1'b1, C_ACK});

        // R7 NAK while held, R10 data-direction OUT, R8 release
        send_tok(P_IN, 4'd0);
        chk("R7 first NAK", {hs_valid, hs_code}, {1'b1, C_NAK});
        send_tok(P_IN, 4'd0);
        chk("R7 repeated NAK", {hs_valid, hs_code}, {1'b1, C_NAK});
        send_tok(P_OUT, 4'd0);
        chk("R10 data token strobe", {data_tok, hs_valid}, 2'b10);
        send_pkt(3, 1'b1);
        chk("R11 data OUT no handshake", hs_valid, 1'b0);
        fw_write(1'b0, 3'b001);
        chk("R8 hold cleared", hold, 1'b0);
        send_tok(P_IN, 4'd0);
        chk("R8 status ACK", {hs_valid, hs_code}, {1'b1, C_ACK});
        send_tok(P_IN, 4'd0);
        chk("R8 transfer ended", {hs_valid, data_tok}, 2'b00);

        // R9 stall on data IN and status OUT once hold released
        rand_bytes();
        pbytes[0][7] = 1'b1;
        open_xfer("R9");
        fw_write(1'b0, 3'b100);
        send_tok(P_IN, 4'd0);
        chk("R10 IN data token strobe", {data_tok, hs_valid}, 2'b10);
        fw_write(1'b0, 3'b111);
        send_tok(P_IN, 4'd0);
        chk("R9 data IN stalled", {hs_valid, hs_code}, {1'b1, C_STALL});
        status_tok(P_OUT);
        chk("R9 R11 status OUT stalled at pkt end", {hs_valid, hs_code}, {1'b1, C_STALL});

        // R9 stall with hold still set gives NAK
        rand_bytes();
        pbytes[0][7] = 1'b0;
        open_xfer("R9b");
        fw_write(1'b0, 3'b010);
        send_tok(P_IN, 4'd0);
        chk("R9 stall held gives NAK", {hs_valid, hs_code}, {1'b1, C_NAK});

        // R13 abort with a pending OUT status, arm dropped
        rand_bytes();
        pbytes[0][7] = 1'b1;
        open_xfer("R13");
        fw_write(1'b0, 3'b100);
        send_tok(P_OUT, 4'd0);
        send_tok(P_SETUP, 4'd0);
        chk("R13 hold re-armed", {hold, stall}, 2'b10);
        send_pkt(8, 1'b1);
        chk("R13 new setup ack", {hs_valid, hs_code}, {1'b1, C_ACK});
        fw_write(1'b0, 3'b001);
        send_tok(P_IN, 4'd0);
        chk("R13 arm dropped, IN is status", {hs_valid, hs_code}, {1'b1, C_ACK});

        // R12 set wins over clear in the same cycle
        fw_write(1'b1, 3'b011);
        tok_valid = 1'b1; tok_pid = P_SETUP; tok_ep = 4'd0;
        fw_we = 1'b1; fw_sel = 1'b1; fw_wdata = 3'b001;
        @(negedge clk);
        tok_valid = 1'b0; fw_we = 1'b0;
        chk("R12 set beats clear", irq_setup_tok, 1'b1);
        send_pkt(0, 1'b1);

        // R6 random transfers in both directions
        for (int it = 0; it < 30; it++) begin
            bit armed;
            int naks;
            logic [1:0] sp, dp;
            rand_bytes();
            armed = 1'($urandom);
            naks = $urandom_range(0, 2);
            open_xfer("R3 rand");
            if (armed) fw_write(1'b0, 3'b100);
            sp = exp_status_pid(armed, pbytes[0]);
            dp = (sp == P_IN) ? P_OUT : P_IN;
            send_tok(dp, 4'd0);
            chk("R6 R10 data direction strobe", {data_tok, hs_valid}, 2'b10);
            if (dp == P_OUT) begin
                send_pkt($urandom_range(0, 4), 1'b1);
                chk("R11 data OUT silent", hs_valid, 1'b0);
            end
            for (int n = 0; n < naks; n++) begin
                status_tok(sp);
                chk("R7 rand NAK", {hs_valid, hs_code}, {1'b1, C_NAK});
            end
            fw_write(1'b0, armed ? 3'b101 : 3'b001);
            status_tok(sp);
            chk("R6 rand status ACK", {hs_valid, hs_code}, {1'b1, C_ACK});
            fw_write(1'b1, 3'b011);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule